// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Unit

This block holds the interrupt state of a serial bus controller. The controller core sends one-cycle event pulses. Each pulse sets a sticky bit in a raw status vector. Two further status bits follow FIFO level signals directly and do not latch. A software-written mask selects which raw bits appear in the masked status, and any masked bit that is set drives a single interrupt line.

Software clears an event by reading a register, not by writing one. Each clearable source has its own clear address, and one further address clears every latched source at once. The unit also keeps a sticky record of why a transmit was aborted. A read of the transmit-abort clear wipes that record, and so does a read of the clear-all address. Register reads are combinational: read data is valid in the same cycle as the read strobe, and the clear takes effect at the following clock edge.

Top module: `intr_status_unit`

## Requirements
- R1: Status bit positions are 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abort, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. A pulse on `evtPulse[k]` for a latched bit k sets raw bit k at the next edge, and the bit stays set until it is cleared. The raw status reads at address 0x34.
- R2: Raw bit 2 equals `rxFullLvl` and raw bit 4 equals `txEmptyLvl` at all times. Event pulses on bits 2 and 4 are ignored, and no clear read changes these two bits.
- R3: The mask register is 12 bits wide, is written and read at 0x30, and resets to zero. The masked status at 0x2C reads as raw AND mask. Unused upper read bits are zero.
- R4: `irq` is high exactly when at least one bit of raw AND mask is set.
- R5: Reading address 0x44 + 4*n (n = 0..9) clears only the n-th latched source. The latched sources are taken in ascending bit order: 0, 1, 3, 5, 6, 7, 8, 9, 10, 11. So 0x54 clears tx_abort and 0x60 clears stop_det.
- R6: Reading 0x40 clears every latched source in one cycle.
- R7: Clear addresses, and any unmapped address, read as zero. A write to a clear address changes nothing.
- R8: If a clearing read and a new pulse for the same source land in the same cycle, the bit stays set.
- R9: The abort-source register reads at 0x80 in its low 16 bits. On each tx_abort pulse, `abortCause` is ORed into it. A read of 0x54 or 0x40 clears it, unless a new tx_abort pulse arrives in that same cycle.
- R10: After reset, the latched raw bits, the mask and the abort source are all zero, and `irq` is low while the level inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe; a read of a clear address clears |
| regWrData | input | 12 | Write data (mask) |
| regRdData | output | 32 | Combinational read data |
| evtPulse | input | 12 | One-cycle event pulses from the core, by status bit |
| rxFullLvl | input | 1 | Receive FIFO at threshold level |
| txEmptyLvl | input | 1 | Transmit FIFO at or below threshold level |
| abortCause | input | 16 | Abort reason bits, valid with the tx_abort pulse |
| irq | output | 1 | Combined masked interrupt |

## Verification
A latched bit that is wrongly set or wrongly left standing shows up on the next raw or masked read. It also shows on `irq` within one cycle whenever that bit is unmasked. A clear decoded to the wrong source leaves the targeted bit set and drops a neighbour, which the read after the clearing read exposes. If the event-versus-clear precedence is wrong, the bit is lost at the very next edge, so the conflict cycle is followed at once by a raw read. An abort-source record that fails to accumulate or to clear is visible on the first read of 0x80 that follows.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int NUM_SRC = 12;
  // Latched (edge) sources; bits 2 and 4 are level-driven
  localparam logic [NUM_SRC-1:0] EDGE_MASK = 12'b1111_1110_1011;
  localparam int NUM_CLR = 10;
  localparam int BIT_RX_FULL  = 2;
  localparam int BIT_TX_EMPTY = 4;
  localparam int BIT_TX_ABORT = 6;

  localparam int OFS_MASKED  = 'h2C;
  localparam int OFS_MASK    = 'h30;
  localparam int OFS_RAW     = 'h34;
  localparam int OFS_CLR_ALL = 'h40;
  localparam int OFS_CLR_0   = 'h44;
  localparam int OFS_ABORT   = 'h80;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_MASKED, SEL_MASK, SEL_RAW, SEL_ABORT
  } rdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrBits;
    logic               maskWr;
    logic               abortClr;
    rdSel_e             rdSel;
  } strobes_t;

  // Map a clear slot number to the status bit it clears
  function automatic logic [NUM_SRC-1:0] slotToBit(input int slot);
    logic [NUM_SRC-1:0] r;
    int seen;
    r = '0;
    seen = 0;
    for (int b = 0; b < NUM_SRC; b++) begin
      if (EDGE_MASK[b]) begin
        if (seen == slot) r[b] = 1'b1;
        seen++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output strobes_t          strb
);
  localparam logic [ADDR_W-1:0] A_MASKED  = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RAW     = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_CLR_ALL = ADDR_W'(OFS_CLR_ALL);
  localparam logic [ADDR_W-1:0] A_ABORT   = ADDR_W'(OFS_ABORT);

  logic [NUM_SRC-1:0] slotMask [NUM_CLR];
  logic               clrAllHit;

  for (genvar s = 0; s < NUM_CLR; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(OFS_CLR_0 + 4 * s);
    localparam logic [NUM_SRC-1:0] SLOT_BIT = slotToBit(s);
    assign slotMask[s] = (regRdEn && regAddr == SLOT_ADDR) ? SLOT_BIT : '0;
  end

  assign clrAllHit = regRdEn && (regAddr == A_CLR_ALL);

  always_comb begin
    strb.clrBits = '0;
    for (int s = 0; s < NUM_CLR; s++) strb.clrBits = strb.clrBits | slotMask[s];
    if (clrAllHit) strb.clrBits = EDGE_MASK;
    strb.abortClr = strb.clrBits[BIT_TX_ABORT];
    strb.maskWr   = regWrEn && (regAddr == A_MASK);
    if (!regRdEn)                 strb.rdSel = SEL_ZERO;
    else if (regAddr == A_MASKED) strb.rdSel = SEL_MASKED;
    else if (regAddr == A_MASK)   strb.rdSel = SEL_MASK;
    else if (regAddr == A_RAW)    strb.rdSel = SEL_RAW;
    else if (regAddr == A_ABORT)  strb.rdSel = SEL_ABORT;
    else                          strb.rdSel = SEL_ZERO;
  end

  // R5: a single-source clear read never touches more than one bit
  p_single_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr != A_CLR_ALL) |-> $onehot0(strb.clrBits));

  // R7: writes never produce clear strobes
  p_write_no_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdEn) |-> (strb.clrBits == '0));
endmodule

// File: rtl/isu_datapath.sv
module isu_datapath
  import isu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ABORT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               rxFullLvl,
  input  logic               txEmptyLvl,
  input  logic [ABORT_W-1:0] abortCause,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irq
);
  logic [NUM_SRC-1:0] rawEdge;
  logic [NUM_SRC-1:0] maskReg;
  logic [ABORT_W-1:0] abortReg;
  logic [NUM_SRC-1:0] levelVec;
  logic [NUM_SRC-1:0] rawView;
  logic [NUM_SRC-1:0] maskedView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawEdge  <= '0;
      maskReg  <= '0;
      abortReg <= '0;
    end else begin
      // new event beats a same-cycle clear
      rawEdge <= ((rawEdge & ~strb.clrBits) | evtPulse) & EDGE_MASK;
      if (strb.maskWr) maskReg <= regWrData;
      abortReg <= (strb.abortClr ? '0 : abortReg)
                | (evtPulse[BIT_TX_ABORT] ? abortCause : '0);
    end
  end

  always_comb begin
    levelVec = '0;
    levelVec[BIT_RX_FULL]  = rxFullLvl;
    levelVec[BIT_TX_EMPTY] = txEmptyLvl;
  end

  assign rawView    = rawEdge | levelVec;
  assign maskedView = rawView & maskReg;
  assign irq        = |maskedView;

  always_comb begin
    unique case (strb.rdSel)
      SEL_MASKED: regRdData = DATA_W'(maskedView);
      SEL_MASK:   regRdData = DATA_W'(maskReg);
      SEL_RAW:    regRdData = DATA_W'(rawView);
      SEL_ABORT:  regRdData = DATA_W'(abortReg);
      default:    regRdData = '0;
    endcase
  end

  // R1: an accepted pulse leaves its bit set
  p_event_sticks_r1: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & EDGE_MASK) != '0) |=>
      ((rawEdge & $past(evtPulse & EDGE_MASK)) == $past(evtPulse & EDGE_MASK)));

  // R5: a clear without a competing pulse empties the bit
  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.clrBits & ~evtPulse) != '0) |=>
      ((rawEdge & $past(strb.clrBits & ~evtPulse)) == '0));

  // R9: abort record wiped by its clear
  p_abort_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.abortClr && !evtPulse[BIT_TX_ABORT]) |=> (abortReg == '0));

  // R3: mask takes written value
  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskWr |=> (maskReg == $past(regWrData)));

  // R4: nothing masked in means quiet line
  p_irq_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irq);
endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import isu_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ABORT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               rxFullLvl,
  input  logic               txEmptyLvl,
  input  logic [ABORT_W-1:0] abortCause,
  output logic               irq
);
  strobes_t strb;

  isu_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .strb(strb)
  );

  isu_datapath #(.DATA_W(DATA_W), .ABORT_W(ABORT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .evtPulse(evtPulse), .rxFullLvl(rxFullLvl), .txEmptyLvl(txEmptyLvl),
    .abortCause(abortCause), .regRdData(regRdData), .irq(irq)
  );
endmodule

// File: tb/test_intr_status_unit.sv
`timescale 1ns/1ps
module test_intr_status_unit;
  localparam logic [11:0] EDGE = 12'b1111_1110_1011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [11:0] evtPulse = '0;
  logic        rxFullLvl = 1'b0;
  logic        txEmptyLvl = 1'b0;
  logic [15:0] abortCause = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic [11:0] mRaw = '0;
  logic [11:0] mMask = '0;
  logic [15:0] mAbort = '0;
  logic [31:0] lastRd = '0;

  always #2.5 clk = ~clk;

  intr_status_unit i_intr_status_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .evtPulse(evtPulse), .rxFullLvl(rxFullLvl), .txEmptyLvl(txEmptyLvl),
    .abortCause(abortCause), .irq(irq)
  );

  function automatic logic [11:0] viewRaw();
    return mRaw | (12'(rxFullLvl) << 2) | (12'(txEmptyLvl) << 4);
  endfunction

  function automatic logic [11:0] slotBit(input int k);
    int b;
    b = (k < 2) ? k : (k == 2) ? 3 : k + 2;
    return 12'(1) << b;
  endfunction

  function automatic logic [11:0] clrOf(input logic [7:0] a);
    if (a == 8'h40) return EDGE;
    for (int k = 0; k < 10; k++) if (a == 8'(8'h44 + 4 * k)) return slotBit(k);
    return '0;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h2C:   return 32'(viewRaw() & mMask);
      8'h30:   return 32'(mMask);
      8'h34:   return 32'(viewRaw());
      8'h80:   return 32'(mAbort);
      default: return '0;
    endcase
  endfunction

  function automatic string addrTag(input logic [7:0] a);
    case (a)
      8'h2C, 8'h30: return "R3";
      8'h34:        return "R1";
      8'h80:        return "R9";
      default:      return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [11:0] ev, input logic rd, input logic wr,
                     input logic [7:0] a, input logic [11:0] wd,
                     input logic [15:0] cause, input string tag);
    logic [11:0] clr;
    evtPulse = ev; regRdEn = rd; regWrEn = wr; regAddr = a;
    regWrData = wd; abortCause = cause;
    #1;
    lastRd = regRdData;
    if (rd) chk((tag == "") ? addrTag(a) : tag, regRdData, expRead(a));
    chk("R4", 32'(irq), 32'(|(viewRaw() & mMask)));
    @(posedge clk);
    clr = rd ? clrOf(a) : '0;
    mAbort = (clr[6] ? 16'h0 : mAbort) | (ev[6] ? cause : 16'h0);
    mRaw = ((mRaw & ~clr) | ev) & EDGE;
    if (wr && a == 8'h30) mMask = wd;
    @(negedge clk);
    evtPulse = '0; regRdEn = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc('0, 1'b1, 1'b0, a, '0, '0, tag);
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    rd(8'h34, "R10"); chk("R10", lastRd, 32'h0);
    rd(8'h30, "R10"); chk("R10", lastRd, 32'h0);
    rd(8'h80, "R10"); chk("R10", lastRd, 32'h0);
    chk("R10", 32'(irq), 32'h0);

    // R1 sticky event bits
    cyc(12'h201, 1'b0, 1'b0, 8'h0, '0, '0, "");
    cyc('0, 1'b0, 1'b0, 8'h0, '0, '0, "");
    rd(8'h34, "R1"); chk("R1", lastRd, 32'h201);

    // R2 pulses on level bits ignored, levels pass through
    cyc(12'h014, 1'b0, 1'b0, 8'h0, '0, '0, "");
    rd(8'h34, "R2"); chk("R2", lastRd, 32'h201);
    rxFullLvl = 1'b1; txEmptyLvl = 1'b1;
    rd(8'h34, "R2"); chk("R2", lastRd, 32'h215);

    // R3/R4 masking
    cyc('0, 1'b0, 1'b1, 8'h30, 12'h200, '0, "R3");
    rd(8'h2C, "R3"); chk("R3", lastRd, 32'h200);
    chk("R4", 32'(irq), 32'h1);

    // R7 write to a clear address ignored, clear reads return 0
    cyc('0, 1'b0, 1'b1, 8'h60, 12'hFFF, '0, "R7");
    rd(8'h34, "R7"); chk("R7", lastRd, 32'h215);
    rd(8'h30, "R7"); chk("R7", lastRd, 32'h200);

    // R8 same-cycle pulse beats clear of stop_det
    cyc(12'h200, 1'b1, 1'b0, 8'h60, '0, '0, "R8");
    chk("R8", lastRd, 32'h0);
    rd(8'h34, "R8"); chk("R8", lastRd, 32'h215);

    // R5 stop_det clear touches only bit 9
    rd(8'h60, "R5");
    rd(8'h34, "R5"); chk("R5", lastRd, 32'h015);
    chk("R4", 32'(irq), 32'h0);

    // R9 abort record accumulates and clears via 0x54
    cyc(12'h040, 1'b0, 1'b0, 8'h0, '0, 16'h0005, "");
    cyc(12'h040, 1'b0, 1'b0, 8'h0, '0, 16'h0010, "");
    rd(8'h80, "R9"); chk("R9", lastRd, 32'h15);
    rd(8'h54, "R9");
    rd(8'h80, "R9"); chk("R9", lastRd, 32'h0);
    rd(8'h34, "R5"); chk("R5", lastRd, 32'h015);

    // R6 clear-all, levels untouched (R2)
    cyc(EDGE, 1'b0, 1'b0, 8'h0, '0, 16'h8000, "");
    rd(8'h34, "R6"); chk("R6", lastRd, 32'hFFF);
    rd(8'h40, "R6"); chk("R7", lastRd, 32'h0);
    rd(8'h34, "R6"); chk("R6", lastRd, 32'h014);
    rd(8'h80, "R9"); chk("R9", lastRd, 32'h0);
    rxFullLvl = 1'b0; txEmptyLvl = 1'b0;

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      logic [11:0] ev;
      logic [7:0]  a;
      int op;
      ev = 12'($urandom) & 12'($urandom) & 12'($urandom);
      op = $urandom % 10;
      if (($urandom % 16) == 0) rxFullLvl = ~rxFullLvl;
      if (($urandom % 16) == 0) txEmptyLvl = ~txEmptyLvl;
      case (op)
        0:       a = 8'h2C;
        1:       a = 8'h30;
        2, 3:    a = 8'h34;
        4:       a = 8'h40;
        5, 6:    a = 8'(8'h44 + 4 * ($urandom % 10));
        7:       a = 8'h80;
        default: a = 8'h70;
      endcase
      if (op == 8 && ($urandom % 2) == 0)
        cyc(ev, 1'b0, 1'b1, 8'h30, 12'($urandom), 16'($urandom), "R3");
      else if (op == 9)
        cyc(ev, 1'b0, 1'b1, 8'(8'h44 + 4 * ($urandom % 10)), 12'hFFF, 16'($urandom), "R7");
      else
        cyc(ev, 1'b1, 1'b0, a, '0, 16'($urandom), "");
    end
    finish();
  end
endmodule